// File: doc/BRIEF.md
# Three-wire serial word memory with self-timed bulk programming

This block is a synthesizable slave that answers like a small three-wire serial word memory. It holds 256 words of 16 bits in on-chip registers. A host raises chip select, then presents bits on the data input. The block takes each bit on a rising edge of the serial clock. A frame holds a start bit, a two-bit opcode and an eight-bit address. Write-type frames then carry a 16-bit data word. The chip select, serial clock and data input are synchronised into the system clock domain before any edge is detected, so the system clock must run several times faster than the serial clock.

The block carries two bulk operations: clearing the whole array, and filling the whole array with one word. Word read, word write and word erase are also present, together with a program-enable latch, so that the bulk operations can be driven and checked. No programming operation begins when its frame ends. It begins on the falling edge of chip select. It then runs for a fixed number of system clocks without any serial clock activity. If the host raises chip select again after a long enough deselect, the data output shows busy (low) and then ready (high). When nothing is shown, the output enable is low, which stands for high impedance.

The controller is one state machine. ST_IDLE waits with chip select low. ST_HUNT skips zeros until it sees a start bit. ST_OPADDR collects the opcode and address. ST_DATA collects a data word. ST_READ shifts a word out. ST_ARMED holds a decoded programming command until chip select falls. ST_SINK ignores everything until chip select falls. ST_BUSY runs the self-timed cycle. ST_RDY shows ready.

These are the transitions:
- ST_IDLE to ST_HUNT on a chip-select rise.
- ST_HUNT to ST_OPADDR on a start bit.
- ST_OPADDR to ST_READ, ST_DATA, ST_ARMED or ST_SINK on the last address bit, according to the opcode.
- ST_DATA to ST_ARMED on the last data bit.
- ST_ARMED to ST_BUSY on a chip-select fall when programming is enabled, and to ST_IDLE when it is not.
- ST_BUSY, at the end of the cycle, to ST_RDY when status is shown, to ST_SINK when chip select is high without status, and to ST_IDLE when chip select is low.
- Every state except ST_IDLE and ST_BUSY goes back to ST_IDLE when chip select falls.

Top module: `mw_eeprom_top`

## Requirements
- R1: Each frame is sampled on rising serial clock edges while chip select is high. Zeros before the first 1 are skipped. The first 1 is the start bit. Two opcode bits follow (10 read, 01 write, 11 erase, 00 special), then eight address bits, MSB first. Write and fill frames then carry 16 data bits, MSB first.
- R2: After the last address bit of a read, the data output is driven with a dummy 0. Each later rising serial clock edge presents the next bit of the addressed word, MSB first, until chip select falls.
- R3: After reset, programming is disabled. A special frame whose address starts 11 enables it, and one whose address starts 00 disables it. While disabled, word write, word erase, fill and clear have no effect and start no busy cycle.
- R4: A special frame whose address starts 10 (clear) sets every bit of every word to 1 once chip select falls.
- R5: A special frame whose address starts 01 (fill), with its data word, writes that word into every location once chip select falls, whatever the locations held before.
- R6: Word write stores its data at the addressed word, and word erase sets that word to all ones. No other word changes.
- R7: A programming operation starts on the falling edge of chip select. It completes after PROG_CYCLES system clocks with no serial clock edges needed.
- R8: If chip select is raised during the cycle after being low for at least CSMIN_CYCLES clocks, the output is driven low while busy. It goes high when the cycle ends and stays high until chip select falls.
- R9: If chip select is raised after a deselect shorter than CSMIN_CYCLES, no status is driven, but the operation still completes.
- R10: With chip select low, the output enable is low. With chip select high and no read or status in progress, it is also low.
- R11: Any frame shifted in during the self-timed cycle is ignored, and the busy status stays valid.
- R12: Reset leaves every word at all ones, programming disabled and the output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, asynchronous to clk |
| sk | input | 1 | Serial clock, asynchronous to clk |
| di | input | 1 | Serial data input |
| dout | output | 1 | Serial data output: read data or busy/ready status |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |

## Verification
The bulk operations are tried on several array contents:
- Clearing an array that holds mixed data shows that every word is reached, not only the ones addressed recently.
- Filling an array that was never erased separates a true overwrite from an AND with the old contents.
- Word writes with 1234, 0F0F and an address at each end tell correct MSB-first bit order and address decode apart from shifted or mirrored ones.
- A read frame preceded by zeros shows that leading zeros are skipped.

The status is observed in three ways: after a long deselect, after a deselect that is too short, and while a second frame is clocked in during the cycle. This shows whether busy timing, status gating and command blocking are handled separately. Frames sent while programming is locked, and after a disable, show that the lock suppresses both the array change and the busy indication.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        OPC_SPECIAL = 2'b00,
        OPC_WRITE   = 2'b01,
        OPC_READ    = 2'b10,
        OPC_ERASE   = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_CLEAR  = 2'b10,
        SUB_UNLOCK = 2'b11
    } sub_e;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_WORD,
        WK_WIPE,
        WK_FILL,
        WK_CLEAR
    } wkind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HUNT,
        ST_OPADDR,
        ST_DATA,
        ST_READ,
        ST_ARMED,
        ST_SINK,
        ST_BUSY,
        ST_RDY
    } st_e;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start && !busy_q) begin
            cnt_q  <= CW'(CYCLES - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (int'(cnt_q) < CYCLES));

    // R7
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> busy_q);

endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  mw_pkg::wkind_e      kind,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [DATA_W-1:0]   rdata
);
    import mw_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                unique case (kind)
                    WK_WORD:  if (waddr == ADDR_W'(i)) mem_q[i] <= wdata;
                    WK_WIPE:  if (waddr == ADDR_W'(i)) mem_q[i] <= '1;
                    WK_FILL:  mem_q[i] <= wdata;
                    WK_CLEAR: mem_q[i] <= '1;
                    default:  ;
                endcase
            end
        end
    end

    assign rdata = mem_q[raddr];

    // R4
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == WK_CLEAR) |=> (mem_q[0] == '1 && mem_q[DEPTH-1] == '1));

    // R5
    fill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == WK_FILL) |=> (mem_q[0] == $past(wdata) && mem_q[DEPTH-1] == $past(wdata)));

endmodule

// File: rtl/mw_eeprom_top.sv
module mw_eeprom_top #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 200,
    parameter int CSMIN_CYCLES = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);
    import mw_pkg::*;

    localparam int FRAME_W = 2 + ADDR_W;
    localparam int MAXB    = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
    localparam int CNT_W   = $clog2(MAXB + 1);
    localparam int LOW_W   = $clog2(CSMIN_CYCLES + 1);

    // synchronised pins and edges
    logic [2:0] pins_s;
    logic       cs_s, sk_s, di_s;
    logic       cs_d_q, sk_d_q;
    logic       cs_rise, sk_rise;

    mw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs, sk, di}),
        .dout  (pins_s)
    );

    assign cs_s    = pins_s[2];
    assign sk_s    = pins_s[1];
    assign di_s    = pins_s[0];
    assign cs_rise = cs_s && !cs_d_q;
    assign sk_rise = sk_s && !sk_d_q;

    // state and datapath registers
    st_e                  state_q, state_d;
    logic [CNT_W-1:0]     bitcnt_q;
    logic [FRAME_W-2:0]   sh_q;
    logic [DATA_W-1:0]    data_q;
    logic [DATA_W:0]      rd_q;
    logic [ADDR_W-1:0]    addr_q;
    wkind_e               kind_q;
    logic                 ewen_q;
    logic                 stat_en_q;
    logic [LOW_W-1:0]     lowcnt_q;

    // frame decode
    logic [FRAME_W-1:0]   fw;
    opc_e                 op;
    sub_e                 sub;
    logic [ADDR_W-1:0]    fa;
    logic                 decode, data_last;
    wkind_e               dec_kind;
    logic                 lowcnt_ok, stat_now;

    // timer and array
    logic                 tmr_start, tmr_busy, tmr_done;
    logic [DATA_W-1:0]    rdata;

    assign fw  = {sh_q, di_s};
    assign op  = opc_e'(fw[FRAME_W-1 -: 2]);
    assign fa  = fw[ADDR_W-1:0];
    assign sub = sub_e'(fa[ADDR_W-1 -: 2]);

    assign decode    = (state_q == ST_OPADDR) && cs_s && sk_rise
                       && (bitcnt_q == CNT_W'(FRAME_W - 1));
    assign data_last = (state_q == ST_DATA) && cs_s && sk_rise
                       && (bitcnt_q == CNT_W'(DATA_W - 1));
    assign lowcnt_ok = (lowcnt_q >= LOW_W'(CSMIN_CYCLES));
    assign stat_now  = cs_rise ? lowcnt_ok : stat_en_q;
    assign tmr_start = (state_q == ST_ARMED) && !cs_s && ewen_q;

    always_comb begin
        dec_kind = WK_NONE;
        unique case (op)
            OPC_WRITE:   dec_kind = WK_WORD;
            OPC_ERASE:   dec_kind = WK_WIPE;
            OPC_READ:    dec_kind = WK_NONE;
            OPC_SPECIAL: begin
                if (sub == SUB_FILL)       dec_kind = WK_FILL;
                else if (sub == SUB_CLEAR) dec_kind = WK_CLEAR;
                else                       dec_kind = WK_NONE;
            end
            default:     dec_kind = WK_NONE;
        endcase
    end

    mw_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    mw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (tmr_done),
        .kind   (kind_q),
        .waddr  (addr_q),
        .wdata  (data_q),
        .raddr  (fa),
        .rdata  (rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_rise) state_d = ST_HUNT;
            ST_HUNT: begin
                if (!cs_s)                 state_d = ST_IDLE;
                else if (sk_rise && di_s)  state_d = ST_OPADDR;
            end
            ST_OPADDR: begin
                if (!cs_s) begin
                    state_d = ST_IDLE;
                end else if (decode) begin
                    unique case (op)
                        OPC_READ:    state_d = ST_READ;
                        OPC_WRITE:   state_d = ST_DATA;
                        OPC_ERASE:   state_d = ST_ARMED;
                        OPC_SPECIAL: begin
                            if (sub == SUB_FILL)       state_d = ST_DATA;
                            else if (sub == SUB_CLEAR) state_d = ST_ARMED;
                            else                       state_d = ST_SINK;
                        end
                        default:     state_d = ST_SINK;
                    endcase
                end
            end
            ST_DATA: begin
                if (!cs_s)          state_d = ST_IDLE;
                else if (data_last) state_d = ST_ARMED;
            end
            ST_ARMED:  if (!cs_s) state_d = ewen_q ? ST_BUSY : ST_IDLE;
            ST_READ:   if (!cs_s) state_d = ST_IDLE;
            ST_SINK:   if (!cs_s) state_d = ST_IDLE;
            ST_BUSY: begin
                if (tmr_done) begin
                    if (!cs_s)         state_d = ST_IDLE;
                    else if (stat_now) state_d = ST_RDY;
                    else               state_d = ST_SINK;
                end
            end
            ST_RDY:    if (!cs_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d_q    <= 1'b0;
            sk_d_q    <= 1'b0;
            bitcnt_q  <= '0;
            sh_q      <= '0;
            data_q    <= '0;
            rd_q      <= '0;
            addr_q    <= '0;
            kind_q    <= WK_NONE;
            ewen_q    <= 1'b0;
            stat_en_q <= 1'b0;
            lowcnt_q  <= '0;
        end else begin
            cs_d_q <= cs_s;
            sk_d_q <= sk_s;

            if (cs_s)           lowcnt_q <= '0;
            else if (!lowcnt_ok) lowcnt_q <= lowcnt_q + 1'b1;

            if (state_d != state_q)
                bitcnt_q <= '0;
            else if (sk_rise && (state_q == ST_OPADDR || state_q == ST_DATA))
                bitcnt_q <= bitcnt_q + 1'b1;

            if (state_q == ST_OPADDR && sk_rise) sh_q   <= fw[FRAME_W-2:0];
            if (state_q == ST_DATA && sk_rise)   data_q <= {data_q[DATA_W-2:0], di_s};

            if (decode) begin
                addr_q <= fa;
                kind_q <= dec_kind;
                if (op == OPC_SPECIAL && sub == SUB_UNLOCK) ewen_q <= 1'b1;
                if (op == OPC_SPECIAL && sub == SUB_LOCK)   ewen_q <= 1'b0;
                if (op == OPC_READ) rd_q <= {1'b0, rdata};
            end else if (state_q == ST_READ && sk_rise) begin
                rd_q <= {rd_q[DATA_W-1:0], 1'b0};
            end

            if (!cs_s)
                stat_en_q <= 1'b0;
            else if (state_q == ST_BUSY && cs_rise)
                stat_en_q <= lowcnt_ok;
        end
    end

    // outputs
    always_comb begin
        dout    = 1'b0;
        dout_oe = 1'b0;
        unique case (state_q)
            ST_READ: begin
                dout    = rd_q[DATA_W];
                dout_oe = 1'b1;
            end
            ST_BUSY: begin
                dout    = 1'b0;
                dout_oe = stat_en_q;
            end
            ST_RDY: begin
                dout    = 1'b1;
                dout_oe = 1'b1;
            end
            default: begin
                dout    = 1'b0;
                dout_oe = 1'b0;
            end
        endcase
    end

    // R10
    hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !cs_d_q) |-> !dout_oe);

    // R3
    wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> ewen_q);

    // R11
    busy_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> (state_q == ST_BUSY));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDY && cs_s) |=> (dout_oe && dout));

    // R2
    read_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decode && op == OPC_READ) |=> (dout_oe && !dout));

endmodule

// File: tb/tb_mw_eeprom_top.sv
module tb_mw_eeprom_top;

    localparam int PROG  = 600;
    localparam int CSMIN = 8;
    localparam int H     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout, dout_oe;

    always #10 clk = ~clk;

    mw_eeprom_top #(
        .ADDR_W(8), .DATA_W(16), .PROG_CYCLES(PROG),
        .CSMIN_CYCLES(CSMIN), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .dout(dout), .dout_oe(dout_oe)
    );

    int total = 0;
    int bad = 0;
    int cs_low_run = 0;
    bit finished = 1'b0;
    logic [15:0] ref_mem [256];
    bit ref_en = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // per-clock model comparison: output must be released while CS is low (R10)
    always @(negedge clk) begin
        if (cs == 1'b0) cs_low_run++;
        else            cs_low_run = 0;
        if (rst_n && cs_low_run > 5)
            chk(dout_oe == 1'b0, "R10", {31'd0, dout_oe}, 32'd0, "output enabled with CS low");
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1, "run did not finish");
        summary();
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        di = b;
        sk = 1'b0;
        tick(H);
        sk = 1'b1;
        tick(H);
        sk = 1'b0;
    endtask

    task automatic hdr(input logic [1:0] op, input logic [7:0] addr, input int nz);
        for (int i = 0; i < nz; i++) pulse(1'b0);
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = 7; i >= 0; i--) pulse(addr[i]);
    endtask

    task automatic put16(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) pulse(d[i]);
    endtask

    task automatic frame_on();
        cs = 1'b1;
        tick(4);
    endtask

    task automatic frame_off();
        cs = 1'b0;
        tick(16);
    endtask

    // shifts a command in and drops CS (leaves CS low, no wait)
    task automatic send_cmd(input logic [1:0] op, input logic [7:0] addr,
                            input bit with_data, input logic [15:0] d);
        frame_on();
        hdr(op, addr, 0);
        if (with_data) put16(d);
        cs = 1'b0;
    endtask

    // reference-model updates
    task automatic m_apply(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] d);
        if (op == 2'b00 && addr[7:6] == 2'b11) ref_en = 1'b1;
        else if (op == 2'b00 && addr[7:6] == 2'b00) ref_en = 1'b0;
        else if (ref_en) begin
            if (op == 2'b01) ref_mem[addr] = d;
            else if (op == 2'b11) ref_mem[addr] = 16'hFFFF;
            else if (op == 2'b00 && addr[7:6] == 2'b01)
                for (int i = 0; i < 256; i++) ref_mem[i] = d;
            else if (op == 2'b00 && addr[7:6] == 2'b10)
                for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
        end
    endtask

    task automatic read_chk(input logic [7:0] addr, input string req, input int nz);
        logic [15:0] w;
        frame_on();
        hdr(2'b10, addr, nz);
        chk(dout_oe && !dout, "R2", {30'd0, dout_oe, dout}, 32'h2, "dummy zero before data");
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0);
            w[i] = dout;
        end
        chk(w === ref_mem[addr], req, {16'd0, w}, {16'd0, ref_mem[addr]}, "read word");
        frame_off();
    endtask

    // CS already low: wait deselect, raise CS, expect busy then ready (R7, R8)
    task automatic status_wait();
        int n;
        n = 0;
        tick(16);
        n += 16;
        cs = 1'b1;
        tick(6);
        n += 6;
        chk(dout_oe && !dout, "R8", {30'd0, dout_oe, dout}, 32'h2, "busy shown");
        while (!(dout_oe && dout) && n < PROG + 40) begin
            tick(1);
            n++;
        end
        chk(n >= PROG - 2 && n <= PROG + 12, "R7", n, PROG, "cycle length to ready");
        tick(20);
        chk(dout_oe && dout, "R8", {30'd0, dout_oe, dout}, 32'h3, "ready held while CS high");
        frame_off();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk(!dout_oe, "R12", {31'd0, dout_oe}, 32'd0, "released after reset");
        cs = 1'b1;
        tick(10);
        chk(!dout_oe, "R10", {31'd0, dout_oe}, 32'd0, "released with CS high, no frame");
        cs = 1'b0;
        tick(10);
        read_chk(8'h00, "R12", 0);

        // locked write has no effect, no busy
        send_cmd(2'b01, 8'h05, 1'b1, 16'h1234);
        m_apply(2'b01, 8'h05, 16'h1234);
        tick(16);
        cs = 1'b1;
        tick(10);
        chk(!dout_oe, "R3", {31'd0, dout_oe}, 32'd0, "no status when locked");
        frame_off();
        read_chk(8'h05, "R3", 0);

        // enable
        send_cmd(2'b00, 8'hC0, 1'b0, 16'h0);
        m_apply(2'b00, 8'hC0, 16'h0);
        tick(16);

        // word writes (R6), read with leading zeros (R1)
        send_cmd(2'b01, 8'h05, 1'b1, 16'h1234);
        m_apply(2'b01, 8'h05, 16'h1234);
        status_wait();
        read_chk(8'h05, "R1", 3);
        send_cmd(2'b01, 8'hFF, 1'b1, 16'h0F0F);
        m_apply(2'b01, 8'hFF, 16'h0F0F);
        status_wait();
        read_chk(8'hFF, "R6", 0);
        read_chk(8'h04, "R6", 0);

        // word erase (R6)
        send_cmd(2'b11, 8'h05, 1'b0, 16'h0);
        m_apply(2'b11, 8'h05, 16'h0);
        status_wait();
        read_chk(8'h05, "R6", 0);
        read_chk(8'hFF, "R6", 0);

        // fill over non-erased contents (R5)
        send_cmd(2'b00, 8'h40, 1'b1, 16'hA5C3);
        m_apply(2'b00, 8'h40, 16'hA5C3);
        status_wait();
        read_chk(8'h00, "R5", 0);
        read_chk(8'h80, "R5", 0);
        read_chk(8'hFF, "R5", 0);

        // clear (R4)
        send_cmd(2'b00, 8'h80, 1'b0, 16'h0);
        m_apply(2'b00, 8'h80, 16'h0);
        status_wait();
        read_chk(8'h00, "R4", 0);
        read_chk(8'h7F, "R4", 0);
        read_chk(8'hFF, "R4", 0);

        // frame during busy ignored (R11)
        send_cmd(2'b00, 8'h40, 1'b1, 16'h5A5A);
        m_apply(2'b00, 8'h40, 16'h5A5A);
        tick(16);
        cs = 1'b1;
        tick(6);
        chk(dout_oe && !dout, "R11", {30'd0, dout_oe, dout}, 32'h2, "busy before frame");
        hdr(2'b01, 8'h03, 0);
        put16(16'h1111);
        chk(dout_oe && !dout, "R11", {30'd0, dout_oe, dout}, 32'h2, "busy kept during frame");
        for (int i = 0; i < PROG; i++) begin
            if (!(dout_oe && dout)) tick(1);
        end
        chk(dout_oe && dout, "R11", {30'd0, dout_oe, dout}, 32'h3, "ready after ignored frame");
        frame_off();
        read_chk(8'h03, "R11", 0);
        read_chk(8'h00, "R11", 0);

        // short deselect: no status, operation still completes (R9)
        send_cmd(2'b00, 8'h80, 1'b0, 16'h0);
        m_apply(2'b00, 8'h80, 16'h0);
        tick(2);
        cs = 1'b1;
        tick(8);
        chk(!dout_oe, "R9", {31'd0, dout_oe}, 32'd0, "no status after short deselect");
        tick(PROG + 20);
        chk(!dout_oe, "R9", {31'd0, dout_oe}, 32'd0, "still released after cycle");
        frame_off();
        read_chk(8'h03, "R9", 0);

        // disable then fill is ignored (R3)
        send_cmd(2'b00, 8'h00, 1'b0, 16'h0);
        m_apply(2'b00, 8'h00, 16'h0);
        tick(16);
        send_cmd(2'b00, 8'h40, 1'b1, 16'h0000);
        m_apply(2'b00, 8'h40, 16'h0000);
        tick(16);
        cs = 1'b1;
        tick(10);
        chk(!dout_oe, "R3", {31'd0, dout_oe}, 32'd0, "no status after disable");
        frame_off();
        read_chk(8'h00, "R3", 0);
        read_chk(8'hFF, "R3", 0);

        summary();
    end

endmodule